// File: doc/BRIEF.md
# Soft Error Memory Test Sequencer

This block exercises a synchronous SRAM to count radiation-induced upsets. It loads the whole array with a selectable data pattern and then runs one of two regimes. In the retention regime it leaves the array untouched for a programmed number of clock cycles and then reads every word once. In the cycling regime it repeats full write and read passes a programmed number of times.

On every read it rebuilds the expected word from the address and compares it with the returned data. It accumulates mismatching bits and mismatching words into running totals. Each failing word is pushed into a small log as its address and its XOR syndrome. After the single-cycle done pulse, a host drains the log to build a fail bitmap and reads the totals, which hold until the next start.

Top module: `seu_mem_tester`

## Requirements
- R1: Each pass writes every address 0..2^ADDR_W-1 once, in increasing order, with the latched pattern. The pattern select `pattern_i` takes four values. 0 gives all zeros and 1 gives all ones. 2 gives a checkerboard with the odd-index bits set at even addresses (0xAA for 8 bits) and inverted at odd addresses. 3 is the inverse of 2.
- R2: With `mode_i`=0 (retention), a single write pass is followed by T+1 cycles with the memory disabled, where T is `hold_cycles_i`, and then a single read pass. `done_o` rises 2*2^ADDR_W+T+2 cycles after the clock edge that accepts start.
- R3: With `mode_i`=1 (cycling), the block runs N write-then-read passes, where N is `pass_count_i` and N=0 counts as 1. `done_o` rises N*(2*2^ADDR_W+1) cycles after the accepting edge. `pass_o` then shows the number of passes run, which is 1 in retention mode.
- R4: The memory returns read data one cycle after the read address. Each comparison pairs that data with the address that was issued in the cycle before.
- R5: Error totals accumulate over every read of every pass of a test and are never overwritten within a test.
- R6: `bit_err_o` adds the popcount of (read XOR expected) for each word read. `word_err_o` adds one for each word whose XOR is nonzero.
- R7: Each failing word pushes {address, XOR syndrome} into a 16-entry first-in first-out log, read through `log_pop_i`. When the log is full, later failures are still counted and the sticky `log_ovf_o` is set.
- R8: A start request while `busy_o` is high is ignored. So is any change of the mode, pattern, hold or pass inputs after the accepting edge.
- R9: `done_o` is high for exactly one cycle. Totals, pass count, log and overflow hold until the next accepted start, which clears all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| mode_i | input | 1 | 0 retention, 1 cycling |
| pattern_i | input | 2 | Pattern select |
| hold_cycles_i | input | HOLD_W | Retention interval T in cycles |
| pass_count_i | input | PASS_W | Number of cycling passes N |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, one cycle latency |
| bit_err_o | output | CNT_W | Accumulated bit errors |
| word_err_o | output | CNT_W | Accumulated word errors |
| pass_o | output | PASS_W | Passes completed |
| log_pop_i | input | 1 | Remove head log entry |
| log_valid_o | output | 1 | Log not empty |
| log_addr_o | output | ADDR_W | Head entry address |
| log_syn_o | output | DATA_W | Head entry syndrome |
| log_ovf_o | output | 1 | Sticky log overflow |

## Verification
Completion is due at fixed offsets from the accepting edge: 2W+T+2 cycles in retention mode and N(2W+1) in cycling mode, with W words. The bench counts edges from the accepting edge and requires `done_o` at exactly that count. The last comparison is folded into the totals on the edge that raises `done_o`, so totals, pass count and overflow are sampled in the done cycle, away from the clock edge, and again some cycles later to confirm they hold. Read errors come from a one-cycle-latency memory model in the bench that XORs a fault mask into the returned data. The expected log, drained after done, is therefore the masked addresses in pass order, truncated to 16 entries.

// File: rtl/seu_tst_pkg.sv
package seu_tst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_HOLD,
    ST_READ,
    ST_FLUSH
  } seq_state_e;

  localparam logic [1:0] PAT_ZERO    = 2'd0;
  localparam logic [1:0] PAT_ONES    = 2'd1;
  localparam logic [1:0] PAT_CHK     = 2'd2;
  localparam logic [1:0] PAT_CHK_INV = 2'd3;
endpackage

// File: rtl/seu_pat_gen.sv
module seu_pat_gen import seu_tst_pkg::*; #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic [1:0]        sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] chk_base;

  for (genvar i = 0; i < DATA_W; i++) begin : g_chk
    assign chk_base[i] = (i % 2 == 1);
  end

  always_comb begin
    unique case (sel_i)
      PAT_ZERO:    data_o = '0;
      PAT_ONES:    data_o = '1;
      PAT_CHK:     data_o = addr_i[0] ? ~chk_base : chk_base;
      default:     data_o = addr_i[0] ? chk_base : ~chk_base;
    endcase
  end
endmodule

// File: rtl/seu_err_cmp.sv
module seu_err_cmp #(
  parameter int DATA_W = 8,
  localparam int CW = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] expect_i,
  output logic [DATA_W-1:0] syn_o,
  output logic [CW-1:0]     nbits_o,
  output logic              bad_o
);
  assign syn_o = rdata_i ^ expect_i;
  assign bad_o = |syn_o;

  always_comb begin
    nbits_o = '0;
    for (int i = 0; i < DATA_W; i++) nbits_o = nbits_o + CW'(syn_o[i]);
  end
endmodule

// File: rtl/seu_fail_log.sv
module seu_fail_log #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] syn_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] syn_o,
  output logic              ovf_o
);
  logic [ADDR_W-1:0] addr_m [DEPTH];
  logic [DATA_W-1:0] syn_m  [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [PTR_W:0]    cnt_q;
  logic              ovf_q, full, do_push, do_pop;

  assign full    = cnt_q == (PTR_W+1)'(DEPTH);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0; ovf_q <= 1'b0;
    end else if (clr_i) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0; ovf_q <= 1'b0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + (PTR_W+1)'(do_push) - (PTR_W+1)'(do_pop);
      if (push_i && full) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) begin
      addr_m[wr_q] <= addr_i;
      syn_m[wr_q]  <= syn_i;
    end
  end

  assign valid_o = cnt_q != '0;
  assign addr_o  = addr_m[rd_q];
  assign syn_o   = syn_m[rd_q];
  assign ovf_o   = ovf_q;

  // push into a full log must leave the sticky flag set
  assert_ovf_on_full_push_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !clr_i) |=> ovf_o);
  assert_depth_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !pop_i && !clr_i) |=> full);
endmodule

// File: rtl/seu_mem_tester.sv
module seu_mem_tester import seu_tst_pkg::*; #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int HOLD_W    = 32,
  parameter int PASS_W    = 16,
  parameter int CNT_W     = 32,
  parameter int LOG_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [1:0]        pattern_i,
  input  logic [HOLD_W-1:0] hold_cycles_i,
  input  logic [PASS_W-1:0] pass_count_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [CNT_W-1:0]  bit_err_o,
  output logic [CNT_W-1:0]  word_err_o,
  output logic [PASS_W-1:0] pass_o,
  input  logic              log_pop_i,
  output logic              log_valid_o,
  output logic [ADDR_W-1:0] log_addr_o,
  output logic [DATA_W-1:0] log_syn_o,
  output logic              log_ovf_o
);
  localparam int CW = $clog2(DATA_W + 1);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q, rd_addr_q;
  logic              mode_q, rd_vld_q, done_q, start_ok, last_addr;
  logic [1:0]        pat_q;
  logic [HOLD_W-1:0] hold_q, hcnt_q;
  logic [PASS_W-1:0] npass_q, pass_q;
  logic [CNT_W-1:0]  bit_err_q, word_err_q;
  logic [DATA_W-1:0] wr_pat, rd_pat, syn;
  logic [CW-1:0]     nbits;
  logic              bad;

  assign start_ok  = (state_q == ST_IDLE) && start_i;
  assign last_addr = &addr_q;

  seu_pat_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wr_pat (
    .sel_i(pat_q), .addr_i(addr_q), .data_o(wr_pat));
  seu_pat_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rd_pat (
    .sel_i(pat_q), .addr_i(rd_addr_q), .data_o(rd_pat));

  seu_err_cmp #(.DATA_W(DATA_W)) i_cmp (
    .rdata_i(mem_rdata_i), .expect_i(rd_pat), .syn_o(syn), .nbits_o(nbits), .bad_o(bad));

  seu_fail_log #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(LOG_DEPTH)) i_log (
    .clk_i, .rst_ni, .clr_i(start_ok), .push_i(rd_vld_q && bad), .addr_i(rd_addr_q),
    .syn_i(syn), .pop_i(log_pop_i), .valid_o(log_valid_o), .addr_o(log_addr_o),
    .syn_o(log_syn_o), .ovf_o(log_ovf_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; addr_q <= '0; rd_addr_q <= '0; rd_vld_q <= 1'b0;
      mode_q <= 1'b0; pat_q <= '0; hold_q <= '0; hcnt_q <= '0;
      npass_q <= '0; pass_q <= '0; done_q <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      rd_vld_q  <= state_q == ST_READ;
      rd_addr_q <= addr_q;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q <= mode_i; pat_q <= pattern_i; hold_q <= hold_cycles_i;
          npass_q <= pass_count_i; addr_q <= '0; pass_q <= '0;
          state_q <= ST_WRITE;
        end
        ST_WRITE: begin
          addr_q <= addr_q + 1'b1;
          if (last_addr) begin
            hcnt_q  <= hold_q;
            state_q <= mode_q ? ST_READ : ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (hcnt_q == '0) state_q <= ST_READ;
          else hcnt_q <= hcnt_q - 1'b1;
        end
        ST_READ: begin
          addr_q <= addr_q + 1'b1;
          if (last_addr) state_q <= ST_FLUSH;
        end
        ST_FLUSH: begin
          pass_q <= pass_q + 1'b1;
          if (!mode_q || (pass_q + PASS_W'(1)) >= npass_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_WRITE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_err_q <= '0; word_err_q <= '0;
    end else if (start_ok) begin
      bit_err_q <= '0; word_err_q <= '0;
    end else if (rd_vld_q) begin
      bit_err_q  <= bit_err_q + CNT_W'(nbits);
      word_err_q <= word_err_q + CNT_W'(bad);
    end
  end

  assign busy_o      = state_q != ST_IDLE;
  assign done_o      = done_q;
  assign mem_en_o    = (state_q == ST_WRITE) || (state_q == ST_READ);
  assign mem_we_o    = state_q == ST_WRITE;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wr_pat;
  assign bit_err_o   = bit_err_q;
  assign word_err_o  = word_err_q;
  assign pass_o      = pass_q;

  assert_hold_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && hcnt_q != '0) |=> !mem_en_o);
  assert_bits_grow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> bit_err_o >= $past(bit_err_o));
  assert_word_le_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_err_o <= bit_err_o);
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(bit_err_o) && $stable(word_err_o) && $stable(pass_o)));
endmodule

// File: tb/test_seu_mem_tester.sv
module test_seu_mem_tester;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int W  = 1 << AW;
  localparam int LOGD = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, mode_i = 1'b0, log_pop_i = 1'b0;
  logic [1:0] pattern_i = '0;
  logic [31:0] hold_cycles_i = '0;
  logic [15:0] pass_count_i = '0;
  logic busy_o, done_o, mem_en_o, mem_we_o, log_valid_o, log_ovf_o;
  logic [AW-1:0] mem_addr_o, log_addr_o;
  logic [DW-1:0] mem_wdata_o, log_syn_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic [31:0] bit_err_o, word_err_o;
  logic [15:0] pass_o;

  logic [DW-1:0] mem_m [W];
  logic [DW-1:0] flip  [W];

  int n_chk = 0, n_fail = 0;

  always #5ns clk_i = ~clk_i;

  seu_mem_tester i_seu_mem_tester (
    .clk_i, .rst_ni, .start_i, .mode_i, .pattern_i, .hold_cycles_i, .pass_count_i,
    .busy_o, .done_o, .mem_en_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .bit_err_o, .word_err_o, .pass_o, .log_pop_i, .log_valid_o, .log_addr_o,
    .log_syn_o, .log_ovf_o);

  // one-cycle-latency memory with a read fault mask
  always @(posedge clk_i) begin
    if (mem_en_o) begin
      if (mem_we_o) mem_m[mem_addr_o] <= mem_wdata_o;
      else mem_rdata_i <= mem_m[mem_addr_o] ^ flip[mem_addr_o];
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat_val(input logic [1:0] p, input int a);
    logic [DW-1:0] base;
    for (int i = 0; i < DW; i++) base[i] = (i % 2 == 1);
    case (p)
      2'd0: return '0;
      2'd1: return '1;
      2'd2: return a[0] ? ~base : base;
      default: return a[0] ? base : ~base;
    endcase
  endfunction

  task automatic run_test(input logic m, input logic [1:0] p, input int hold, input int n,
                          input bit mid);
    int k, passes, exp_cyc, eb, ew, nlog, bad_mem;
    int la [LOGD];
    int ls [LOGD];
    bit ovf;
    passes  = (m == 1'b0) ? 1 : ((n == 0) ? 1 : n);
    exp_cyc = (m == 1'b0) ? (2 * W + hold + 2) : passes * (2 * W + 1);
    eb = 0; ew = 0; nlog = 0; ovf = 1'b0;
    for (int ps = 0; ps < passes; ps++)
      for (int a = 0; a < W; a++)
        if (flip[a] != '0) begin
          eb += $countones(flip[a]);
          ew++;
          if (nlog < LOGD) begin la[nlog] = a; ls[nlog] = int'(flip[a]); nlog++; end
          else ovf = 1'b1;
        end
    @(negedge clk_i);
    mode_i = m; pattern_i = p; hold_cycles_i = 32'(hold); pass_count_i = 16'(n); start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    k = 0;
    while (!done_o && k < 50000) begin
      @(posedge clk_i);
      k++;
      @(negedge clk_i);
      start_i = mid && (k == 40);
      if (mid && k == 40) begin
        mode_i = ~m; pattern_i = ~p; pass_count_i = 16'd7; hold_cycles_i = 32'd3;
      end
    end
    start_i = 1'b0;
    chk(k == exp_cyc, (m ? "R3 done time" : "R2 done time"), k, exp_cyc);
    if (mid) chk(k == exp_cyc, "R8 start while busy ignored", k, exp_cyc);
    chk(pass_o == 16'(passes), "R3 pass count", pass_o, passes);
    chk(bit_err_o == 32'(eb), "R6 R5 bit errors", bit_err_o, eb);
    chk(word_err_o == 32'(ew), "R6 R5 word errors", word_err_o, ew);
    chk(log_ovf_o == ovf, "R7 overflow flag", log_ovf_o, ovf);
    bad_mem = 0;
    for (int a = 0; a < W; a++) if (mem_m[a] !== pat_val(p, a)) bad_mem++;
    chk(bad_mem == 0, "R1 pattern contents", bad_mem, 0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(!done_o, "R9 done one cycle", done_o, 0);
    repeat (5) @(negedge clk_i);
    chk(bit_err_o == 32'(eb) && word_err_o == 32'(ew) && pass_o == 16'(passes),
        "R9 totals hold", bit_err_o, eb);
    // drain the log: expected order is pass order, R4 address alignment
    for (int e = 0; e < nlog; e++) begin
      chk(log_valid_o, "R7 log entry present", log_valid_o, 1);
      chk(int'(log_addr_o) == la[e], "R4 R7 log address", log_addr_o, la[e]);
      chk(int'(log_syn_o) == ls[e], "R7 log syndrome", log_syn_o, ls[e]);
      log_pop_i = 1'b1;
      @(posedge clk_i);
      @(negedge clk_i);
      log_pop_i = 1'b0;
    end
    chk(!log_valid_o, "R7 log drained", log_valid_o, 0);
  endtask

  initial begin
    #1900us;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int a = 0; a < W; a++) begin flip[a] = '0; mem_m[a] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_en_o, "R9 reset idle", busy_o, 0);
    chk(bit_err_o == 0 && word_err_o == 0 && !log_valid_o && !log_ovf_o,
        "R9 reset totals", bit_err_o, 0);

    // retention, zeros, three faulty words
    flip[3] = 8'h81; flip[10] = 8'h01; flip[31] = 8'hFF;
    run_test(1'b0, 2'd0, 5, 0, 1'b0);

    // cycling, checkerboard, three passes, start pulse while busy
    run_test(1'b1, 2'd2, 0, 3, 1'b1);

    // retention, inverse checkerboard, T=0, 20 faulty words overflow the log
    for (int a = 0; a < W; a++) flip[a] = (a < 20) ? DW'(1 << (a % DW)) : '0;
    run_test(1'b0, 2'd3, 0, 0, 1'b0);

    // cycling, ones, N=0 runs one pass; new start clears overflow and totals
    for (int a = 0; a < W; a++) flip[a] = '0;
    run_test(1'b1, 2'd1, 0, 0, 1'b0);

    // cycling, two passes, one faulty word on a high address
    flip[17] = 8'h3C;
    run_test(1'b1, 2'd2, 0, 2, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule